// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block carries out one auxiliary-channel transaction at a time for a display link controller. A caller supplies a command type, a 20-bit target address, a byte count from 1 to 16 and up to 16 write bytes packed as four 32-bit words, then pulses a start input. The sequencer first waits for the channel to become free, then requests ownership and waits for the grant. With ownership held, it checks that a sink is attached. It then runs attempts until one ends with a clean status, or until it hits a timeout or the retry limit.

Each attempt opens with a one-cycle reset pulse to the link layer. From the second attempt on, a spacing delay follows the reset. The request line is then held until the link layer reports completion together with its status. Write payloads are presented before the first attempt. Read payloads are captured when an attempt completes cleanly. On every exit the block drops ownership and pulses a done strobe together with a two-bit result. All waits count microseconds from a tick produced by a parameterised clock divider. The line encoding and the analog front end are outside the block: a simple request/response port to a link-layer model replaces them.

Top module: `aux_retry_seq`

## Requirements
- R1: After reset, busy_o, done_o, own_req_o, xact_req_o and xact_rst_o are all low.
- R2: If chan_busy_i stays high for IDLE_US microseconds after start, the block ends with result 2'b01 (busy) and never raises own_req_o.
- R3: Once the channel is free, own_req_o rises; if own_gnt_i does not follow within GNT_US microseconds, the block ends with result 2'b01 and own_req_o low.
- R4: If sink_present_i is low once the grant arrives, the block ends with result 2'b10 (no sink) and issues no xact_rst_o or xact_req_o.
- R5: ctrl_o holds the command type in bits [15:12], zero in bits [11:4] and the byte count minus one in bits [3:0]; addr_o holds the start address; both are captured at start.
- R6: For a write command (cmd_i bit 0 clear), tx_words_o byte k (bits 8k+7:8k) equals wdata_i byte k for k below the count and is zero above it; for a read command tx_words_o is zero.
- R7: When done_o reports result 2'b00 for a read command (cmd_i bit 0 set), rdata_o byte k equals rx_words_i byte k at completion for k below the count and is zero above it; for all other outcomes rdata_o is zero.
- R8: Each attempt begins with xact_rst_o high for exactly one cycle before xact_req_o rises; on the first attempt xact_req_o rises two cycles after the pulse, and on later attempts at least GAP_US microseconds after it.
- R9: xact_req_o stays high until xact_done_i; if completion does not come within DONE_US microseconds, the block ends with result 2'b11 (failed) without retrying.
- R10: An attempt succeeds only when xact_stat_i is zero at completion (result 2'b00); otherwise the block retries, making at most MAX_TRIES attempts, and ends with result 2'b11 if all of them fail.
- R11: In the cycle done_o is high, own_req_o and xact_req_o are low.
- R12: done_o is high for exactly one cycle per started transaction, busy_o is high from start until that cycle, and a start_i pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| cmd_i | input | 4 | Command type; bit 0 set means read |
| addr_i | input | 20 | Target address |
| len_i | input | 5 | Byte count, 1 to 16 |
| wdata_i | input | 128 | Write payload, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end strobe |
| result_o | output | 2 | 00 ok, 01 busy, 10 no sink, 11 failed; valid with done_o |
| rdata_o | output | 128 | Read payload |
| chan_busy_i | input | 1 | Channel has a pending request or is owned |
| own_req_o | output | 1 | Ownership request |
| own_gnt_i | input | 1 | Ownership grant |
| sink_present_i | input | 1 | Sink attached |
| xact_rst_o | output | 1 | Attempt reset pulse |
| xact_req_o | output | 1 | Attempt request, held until completion |
| xact_done_i | input | 1 | Attempt completion pulse |
| xact_stat_i | input | 8 | Error and reply status at completion |
| ctrl_o | output | 16 | Command and size control word |
| addr_o | output | 20 | Latched address |
| tx_words_o | output | 128 | Transmit words |
| rx_words_i | input | 128 | Receive words |

## Verification
The bench builds the block with CLK_DIV=4, IDLE_US=10, GNT_US=10, DONE_US=10, GAP_US=6 and MAX_TRIES=4. With these values every timeout and the full retry budget fit in a few hundred cycles. A link-layer model can then be made to fail a chosen number of attempts, including exactly the last allowed one and one more than allowed, and to never complete. The short spacing delay also keeps the gap between the retry pulse and the request measurable against its lower bound.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_BUSY   = 2'd1,
    RES_NOSINK = 2'd2,
    RES_FAIL   = 2'd3
  } aux_res_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_FREE, ST_WAIT_GNT, ST_CHK_SINK, ST_RST_HI,
    ST_RST_LO, ST_GAP, ST_POLL, ST_EVAL, ST_FINISH
  } aux_st_e;
endpackage

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
  parameter int CLK_DIV = 100,
  parameter int CNT_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick      = (div_q == DIV_W'(CLK_DIV - 1));
  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick && !expired_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // microsecond count never runs past the active limit
  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q <= limit_i) || $changed(limit_i));
endmodule

// File: rtl/aux_byte_mask.sv
module aux_byte_mask #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input  logic [8*MAX_BYTES-1:0] data_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic [8*MAX_BYTES-1:0] data_o
);
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign data_o[8*b +: 8] = (LEN_W'(b) < len_i) ? data_i[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
  import aux_seq_pkg::*;
#(
  parameter int CLK_DIV   = 100,
  parameter int IDLE_US   = 1000,
  parameter int GNT_US    = 1000,
  parameter int DONE_US   = 1000,
  parameter int GAP_US    = 400,
  parameter int MAX_TRIES = 32,
  parameter int ADDR_W    = 20,
  parameter int CMD_W     = 4,
  parameter int CMD_LSB   = 12,
  parameter int STAT_W    = 8,
  parameter int MAX_BYTES = 16,
  localparam int PAY_W    = 8 * MAX_BYTES,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int CTRL_W   = CMD_LSB + CMD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PAY_W-1:0]  wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [PAY_W-1:0]  rdata_o,
  input  logic              chan_busy_i,
  output logic              own_req_o,
  input  logic              own_gnt_i,
  input  logic              sink_present_i,
  output logic              xact_rst_o,
  output logic              xact_req_o,
  input  logic              xact_done_i,
  input  logic [STAT_W-1:0] xact_stat_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAY_W-1:0]  tx_words_o,
  input  logic [PAY_W-1:0]  rx_words_i
);
  localparam int SIZE_W = $clog2(MAX_BYTES);
  localparam int M1     = (IDLE_US > GNT_US) ? IDLE_US : GNT_US;
  localparam int M2     = (DONE_US > GAP_US) ? DONE_US : GAP_US;
  localparam int MAX_US = (M1 > M2) ? M1 : M2;
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam int TRY_W  = (MAX_TRIES > 2) ? $clog2(MAX_TRIES) : 1;

  aux_st_e           state_q, state_d;
  aux_res_e          res_q, res_d;
  logic [TRY_W-1:0]  tries_q;
  logic              inc_try;
  logic [STAT_W-1:0] stat_q;
  logic              is_rd_q;
  logic [LEN_W-1:0]  len_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAY_W-1:0]  tx_q, rdata_q, tx_masked, rx_masked;
  logic              tmr_clr, tmr_exp;
  logic [CNT_W-1:0]  tmr_lim;
  logic              take;

  aux_byte_mask #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_tx_mask (
    .data_i(wdata_i), .len_i(len_i), .data_o(tx_masked));

  aux_byte_mask #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_rx_mask (
    .data_i(rx_words_i), .len_i(len_q), .data_o(rx_masked));

  aux_us_timer #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .limit_i(tmr_lim), .expired_o(tmr_exp));

  always_comb begin
    unique case (state_q)
      ST_WAIT_FREE: tmr_lim = CNT_W'(IDLE_US);
      ST_WAIT_GNT:  tmr_lim = CNT_W'(GNT_US);
      ST_GAP:       tmr_lim = CNT_W'(GAP_US);
      ST_POLL:      tmr_lim = CNT_W'(DONE_US);
      default:      tmr_lim = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    inc_try = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_WAIT_FREE;
      ST_WAIT_FREE: if (!chan_busy_i) state_d = ST_WAIT_GNT;
                    else if (tmr_exp) begin res_d = RES_BUSY; state_d = ST_FINISH; end
      ST_WAIT_GNT:  if (own_gnt_i) state_d = ST_CHK_SINK;
                    else if (tmr_exp) begin res_d = RES_BUSY; state_d = ST_FINISH; end
      ST_CHK_SINK:  if (!sink_present_i) begin res_d = RES_NOSINK; state_d = ST_FINISH; end
                    else state_d = ST_RST_HI;
      ST_RST_HI:    state_d = ST_RST_LO;
      ST_RST_LO:    state_d = (tries_q != '0) ? ST_GAP : ST_POLL;
      ST_GAP:       if (tmr_exp) state_d = ST_POLL;
      ST_POLL:      if (xact_done_i) state_d = ST_EVAL;
                    else if (tmr_exp) begin res_d = RES_FAIL; state_d = ST_FINISH; end
      ST_EVAL: begin
        if (stat_q == '0) begin
          res_d = RES_OK; state_d = ST_FINISH;
        end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
          res_d = RES_FAIL; state_d = ST_FINISH;
        end else begin
          inc_try = 1'b1; state_d = ST_RST_HI;
        end
      end
      ST_FINISH:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);
  assign take    = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
      tries_q <= '0;
      stat_q  <= '0;
      is_rd_q <= 1'b0;
      len_q   <= '0;
      ctrl_q  <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (take) begin
        is_rd_q <= cmd_i[0];
        len_q   <= len_i;
        addr_q  <= addr_i;
        ctrl_q  <= '0;
        ctrl_q[CTRL_W-1:CMD_LSB] <= cmd_i;
        ctrl_q[SIZE_W-1:0]       <= SIZE_W'(len_i - LEN_W'(1));
        tx_q    <= cmd_i[0] ? '0 : tx_masked;
        tries_q <= '0;
        rdata_q <= '0;
      end
      if (inc_try) tries_q <= tries_q + 1'b1;
      if (state_q == ST_POLL && xact_done_i) begin
        stat_q  <= xact_stat_i;
        rdata_q <= (is_rd_q && xact_stat_i == '0) ? rx_masked : '0;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FINISH);
  assign result_o   = res_q;
  assign rdata_o    = rdata_q;
  assign own_req_o  = state_q inside {ST_WAIT_GNT, ST_CHK_SINK, ST_RST_HI,
                                      ST_RST_LO, ST_GAP, ST_POLL, ST_EVAL};
  assign xact_rst_o = (state_q == ST_RST_HI);
  assign xact_req_o = (state_q == ST_POLL);
  assign ctrl_o     = ctrl_q;
  assign addr_o     = addr_q;
  assign tx_words_o = tx_q;

  a_r11_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !own_req_o && !xact_req_o);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(addr_o) && $stable(ctrl_o));

  a_r8_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xact_rst_o |=> !xact_rst_o && !xact_req_o);

  a_r8_rst_before_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xact_req_o) && tries_q == '0 |-> $past(xact_rst_o, 2));

  a_r10_ok_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o == RES_OK |-> stat_q == '0);
endmodule

// File: tb/tb_aux_retry_seq.sv
module tb_aux_retry_seq;
  localparam int CD = 4, IDL = 10, GNT = 10, DON = 10, GAP = 6, MT = 4;
  localparam logic [127:0] WPAT = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  localparam logic [127:0] RPAT = 128'hc0ffee11deadbeef5566778899aabbcc;

  typedef struct packed {
    logic [3:0] cmd;
    logic [4:0] len;
    logic       chb;
    logic       gen;
    logic       snk;
    logic       hang;
    logic [3:0] fail;
    logic [1:0] res;
    logic [3:0] rsts;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'h9, 5'd4,  1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'd0, 4'd1},
    '{4'h8, 5'd16, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'd0, 4'd1},
    '{4'h9, 5'd2,  1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 2'd1, 4'd0},
    '{4'h9, 5'd2,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 2'd1, 4'd0},
    '{4'h8, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 2'd2, 4'd0},
    '{4'h9, 5'd8,  1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 2'd0, 4'd3},
    '{4'h8, 5'd5,  1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 2'd0, 4'd4},
    '{4'h9, 5'd6,  1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 2'd3, 4'd4},
    '{4'h9, 5'd4,  1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 2'd3, 4'd1},
    '{4'h1, 5'd1,  1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 2'd0, 4'd2},
    '{4'h4, 5'd7,  1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'd0, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         start_i = 1'b0;
  logic [3:0]   cmd_i = '0;
  logic [19:0]  addr_i = '0;
  logic [4:0]   len_i = 5'd1;
  logic [127:0] wdata_i = '0;
  logic         busy_o, done_o, own_req_o, xact_rst_o, xact_req_o;
  logic [1:0]   result_o;
  logic [127:0] rdata_o, tx_words_o;
  logic [15:0]  ctrl_o;
  logic [19:0]  addr_o;

  logic m_chb = 1'b0, m_gen = 1'b1, m_snk = 1'b1, m_hang = 1'b0, mclr = 1'b0;
  int   m_fail = 0;
  logic gnt_q, done_q;
  logic [7:0] stat_q;
  logic req_d, sent, own_seen;
  int lat, rst_cnt, req_cnt, rst_cyc, first_gap, last_gap, cyc;
  int errors = 0, checks = 0;

  aux_retry_seq #(.CLK_DIV(CD), .IDLE_US(IDL), .GNT_US(GNT), .DONE_US(DON),
                  .GAP_US(GAP), .MAX_TRIES(MT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .cmd_i, .addr_i, .len_i, .wdata_i,
    .busy_o, .done_o, .result_o, .rdata_o,
    .chan_busy_i(m_chb), .own_req_o, .own_gnt_i(gnt_q), .sink_present_i(m_snk),
    .xact_rst_o, .xact_req_o, .xact_done_i(done_q), .xact_stat_i(stat_q),
    .ctrl_o, .addr_o, .tx_words_o, .rx_words_i(RPAT));

  // link-layer model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; gnt_q <= 0; done_q <= 0; stat_q <= 0; req_d <= 0; sent <= 0;
      own_seen <= 0; lat <= 0; rst_cnt <= 0; req_cnt <= 0; rst_cyc <= 0;
      first_gap <= 0; last_gap <= 0;
    end else begin
      cyc    <= cyc + 1;
      req_d  <= xact_req_o;
      gnt_q  <= own_req_o && m_gen;
      done_q <= 1'b0;
      if (mclr) begin
        own_seen <= 0; rst_cnt <= 0; req_cnt <= 0; first_gap <= 0; last_gap <= 0;
      end else begin
        if (own_req_o) own_seen <= 1'b1;
        if (xact_rst_o) begin rst_cnt <= rst_cnt + 1; rst_cyc <= cyc; end
        if (xact_req_o && !req_d) begin
          req_cnt <= req_cnt + 1;
          if (req_cnt == 0) first_gap <= cyc - rst_cyc;
          last_gap <= cyc - rst_cyc;
        end
      end
      if (!xact_req_o) begin
        sent <= 1'b0; lat <= 0;
      end else if (!m_hang && !sent) begin
        if (lat == 3) begin
          done_q <= 1'b1; sent <= 1'b1; lat <= 0;
          stat_q <= (req_cnt <= m_fail) ? 8'h21 : 8'h00;
        end else lat <= lat + 1;
      end
    end
  end

  function automatic logic [127:0] mask(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int k = 0; k < 16; k++) if (k < n) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a, input logic [4:0] l,
                     output int n, output bit got);
    @(negedge clk);
    cmd_i = c; addr_i = a; len_i = l; wdata_i = WPAT; start_i = 1'b1; mclr = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mclr = 1'b0; n = 1; got = 1'b0;
    while (!got && n < 3000) begin
      if (done_o) got = 1'b1;
      else begin @(negedge clk); n++; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit got;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, done_o, own_req_o, xact_req_o, xact_rst_o} == 5'b0, "R1",
        "outputs in reset", {busy_o, done_o, own_req_o, xact_req_o, xact_rst_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, own_req_o, xact_req_o, xact_rst_o} == 5'b0, "R1",
        "outputs after reset", {busy_o, done_o, own_req_o, xact_req_o, xact_rst_o}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      logic [19:0] a = 20'h10000 + 20'(i * 'h123);
      logic [127:0] etx, erx;
      string rt;
      m_chb = v.chb; m_gen = v.gen; m_snk = v.snk; m_hang = v.hang; m_fail = int'(v.fail);
      run(v.cmd, a, v.len, n, got);
      chk(got, "R12", "done seen", 128'(got), 1);
      case (v.res)
        2'd0: rt = "R10";
        2'd1: rt = v.chb ? "R2" : "R3";
        2'd2: rt = "R4";
        default: rt = v.hang ? "R9" : "R10";
      endcase
      chk(result_o == v.res, rt, $sformatf("result vec %0d", i), 128'(result_o), 128'(v.res));
      chk(rst_cnt == int'(v.rsts), v.res == 2'd2 ? "R4" : "R10",
          $sformatf("attempts vec %0d", i), 128'(rst_cnt), 128'(v.rsts));
      chk(!own_req_o && !xact_req_o, "R11", "released at done",
          {own_req_o, xact_req_o}, 0);
      chk(ctrl_o == {v.cmd, 8'h00, 4'(v.len - 5'd1)} && addr_o == a, "R5",
          $sformatf("ctrl/addr vec %0d", i), {ctrl_o, addr_o}, {v.cmd, 8'h00, 4'(v.len - 5'd1), a});
      etx = v.cmd[0] ? '0 : mask(WPAT, int'(v.len));
      chk(tx_words_o == etx, "R6", $sformatf("tx vec %0d", i), tx_words_o, etx);
      erx = (v.cmd[0] && v.res == 2'd0) ? mask(RPAT, int'(v.len)) : '0;
      chk(rdata_o == erx, "R7", $sformatf("rdata vec %0d", i), rdata_o, erx);
      if (v.chb) begin
        chk(!own_seen, "R2", "no ownership request", 128'(own_seen), 0);
        chk(n >= IDL * CD, "R2", "idle wait length", 128'(n), 128'(IDL * CD));
      end
      if (!v.chb && !v.gen)
        chk(own_seen && n >= GNT * CD, "R3", "grant wait", 128'(n), 128'(GNT * CD));
      if (v.hang)
        chk(n >= DON * CD, "R9", "completion wait", 128'(n), 128'(DON * CD));
      if (v.fail == 4'd2) begin
        chk(first_gap == 2, "R8", "first attempt spacing", 128'(first_gap), 2);
        chk(last_gap >= GAP * CD, "R8", "retry spacing", 128'(last_gap), 128'(GAP * CD));
      end
      @(negedge clk);
      chk(!done_o && !busy_o, "R12", "single done cycle", {done_o, busy_o}, 0);
    end

    // R12: start while busy is ignored
    m_chb = 0; m_gen = 1; m_snk = 1; m_hang = 1; m_fail = 0;
    @(negedge clk);
    cmd_i = 4'h9; addr_i = 20'h0abcd; len_i = 5'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    cmd_i = 4'h8; addr_i = 20'h05555; len_i = 5'd9; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk(addr_o == 20'h0abcd && ctrl_o == 16'h9003, "R12", "start while busy ignored",
        {addr_o, ctrl_o}, {20'h0abcd, 16'h9003});
    chk(result_o == 2'd3, "R9", "hang result", 128'(result_o), 3);
    n = 0;
    repeat (20) begin @(negedge clk); if (done_o || busy_o) n++; end
    chk(n == 0, "R12", "no second transaction", 128'(n), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule